// File: doc/BRIEF.md
# Three-Operand Register-File Datapath

This block is a single-cycle execution datapath built around eight 16-bit general registers. On every rising clock edge it reads two source registers, combines them in an arithmetic-logic unit using the function named by a 3-bit opcode, and stores the result in a destination register. The second operand can be replaced by a 16-bit immediate word. That lets one instruction add a constant to a register, or load a constant into a register that has first been cleared.

A surrounding sequencer presents one instruction per cycle. An instruction is made of the opcode, a destination index, two source indices, the immediate word, an immediate-select bit and a write enable. A separate debug index reads out any register combinationally, so the contents can be observed without disturbing execution. Arithmetic wraps modulo 2^16. The block has no carry, overflow or other status output.

Top module: `rfalu_top`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, all eight registers become zero. Reset is synchronous.
- R2: Opcode 000 writes src_a + operand B, modulo 2^16, into the destination register at the next rising edge. For example, destination 4, sources 0 and 3 gives reg4 = reg0 + reg3.
- R3: Opcode 001 writes src_a − operand B, modulo 2^16, into the destination register.
- R4: Opcodes 010, 011 and 100 write the bitwise AND, OR and XOR of src_a and operand B.
- R5: Opcode 101 copies the src_a register unchanged into the destination register.
- R6: Opcode 110 writes src_a shifted left by one bit, and opcode 111 writes src_a shifted right by one bit. In both cases the vacated bit is filled with zero.
- R7: When `use_imm` is 1, operand B is the `imm` word and `src_b` has no effect on the result. When `use_imm` is 0, operand B is the register selected by `src_b`.
- R8: When `wr_en` is 0, no register changes value, whatever the other inputs are.
- R9: A source index equal to the destination index reads the register's value from before the edge, so the result is computed from the old value.
- R10: `dbg_data` shows, combinationally, the current contents of the register selected by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, clears all registers |
| op | input | 3 | ALU function code |
| dst | input | 3 | Destination register index |
| src_a | input | 3 | First-operand register index |
| src_b | input | 3 | Second-operand register index |
| imm | input | 16 | Immediate word |
| use_imm | input | 1 | Selects `imm` as the second operand |
| wr_en | input | 1 | Enables the register write this cycle |
| dbg_sel | input | 3 | Debug read index |
| dbg_data | output | 16 | Contents of the register picked by `dbg_sel` |

## Verification
The assertions assume that `op`, `wr_en`, `use_imm`, `imm` and the indices are known, non-X values at every rising edge after reset is released. They also assume that reset is held low for at least one edge before any instruction is applied. The bench drives all inputs at the falling edge from fully defined values and holds reset low for several cycles at the start. Its random instructions draw every field over its full range, and it mixes in directed cases for wraparound, source-equals-destination, an ignored `src_b` and disabled writes.

// File: rtl/rfalu_pkg.sv
// Package: shared widths and the opcode type for the register-file datapath.
// Assumes a 3-bit opcode space that is fully decoded.
package rfalu_pkg;

    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100,
        OP_MOV = 3'b101,
        OP_SHL = 3'b110,
        OP_SHR = 3'b111
    } alu_op_e;

endpackage

// File: rtl/rfalu_regfile.sv
// Module: register file with NRD combinational read ports and one write port.
// Assumes: write happens on the rising edge when wr_en is high; reset is
// synchronous and active-low and clears every entry. Reads return the value
// held before the edge, so a read of the register being written sees old data.
module rfalu_regfile #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned NREG  = 8,
    parameter int unsigned NRD   = 3,
    localparam int unsigned AW   = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [WIDTH-1:0]     wr_data,
    input  logic [NRD-1:0][AW-1:0]    rd_addr,
    output logic [NRD-1:0][WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] regs [NREG];
    logic [NREG*WIDTH-1:0] flat;
    logic                  any_set;

    // Storage update: clear on reset, otherwise write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    // One combinational read multiplexer per port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = regs[rd_addr[p]];
    end

    // Flattened view of the storage, used only by the checks below.
    always_comb begin
        any_set = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            flat[i*WIDTH +: WIDTH] = regs[i];
            any_set = any_set | (|regs[i]);
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !any_set); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flat)); // R8
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(wr_addr)] == $past(wr_data)); // R2

endmodule

// File: rtl/rfalu_alu.sv
// Module: combinational ALU for the datapath.
// Assumes operands are already selected; every opcode produces a result.
// clk and rst_n are used only to sample the built-in checks.
module rfalu_alu
    import rfalu_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result
);

    // Function selection; arithmetic wraps at WIDTH bits.
    always_comb begin
        unique case (op)
            OP_ADD:  result = opnd_a + opnd_b;
            OP_SUB:  result = opnd_a - opnd_b;
            OP_AND:  result = opnd_a & opnd_b;
            OP_OR:   result = opnd_a | opnd_b;
            OP_XOR:  result = opnd_a ^ opnd_b;
            OP_MOV:  result = opnd_a;
            OP_SHL:  result = {opnd_a[WIDTH-2:0], 1'b0};
            OP_SHR:  result = {1'b0, opnd_a[WIDTH-1:1]};
            default: result = '0;
        endcase
    end

    AST_ADD_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD) |-> ((result - opnd_b) == opnd_a)); // R2
    AST_SUB_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SUB) |-> ((result + opnd_b) == opnd_a)); // R3
    AST_MOVE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MOV) |-> (result == opnd_a)); // R5
    AST_SHIFT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHL) |-> (result[0] == 1'b0 && result[WIDTH-1:1] == opnd_a[WIDTH-2:0])); // R6

endmodule

// File: rtl/rfalu_top.sv
// Module: single-cycle three-operand datapath (register file + ALU).
// Assumes one instruction is presented per cycle; use_imm replaces the
// second register operand with imm. A debug port reads any register.
module rfalu_top
    import rfalu_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned NREG  = 8,
    localparam int unsigned AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op,
    input  logic [AW-1:0]    dst,
    input  logic [AW-1:0]    src_a,
    input  logic [AW-1:0]    src_b,
    input  logic [WIDTH-1:0] imm,
    input  logic             use_imm,
    input  logic             wr_en,
    input  logic [AW-1:0]    dbg_sel,
    output logic [WIDTH-1:0] dbg_data
);

    localparam int unsigned NRD   = 3;
    localparam int unsigned P_A   = 0;
    localparam int unsigned P_B   = 1;
    localparam int unsigned P_DBG = 2;

    logic [NRD-1:0][AW-1:0]    rd_addr;
    logic [NRD-1:0][WIDTH-1:0] rd_data;
    logic [WIDTH-1:0]          opnd_b;
    logic [WIDTH-1:0]          alu_res;
    alu_op_e                   op_e;

    // Read-port address routing.
    always_comb begin
        rd_addr[P_A]   = src_a;
        rd_addr[P_B]   = src_b;
        rd_addr[P_DBG] = dbg_sel;
    end

    // Second-operand source: immediate word or register B.
    always_comb begin
        opnd_b = use_imm ? imm : rd_data[P_B];
        op_e   = alu_op_e'(op);
    end

    rfalu_regfile #(.WIDTH(WIDTH), .NREG(NREG), .NRD(NRD)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (dst),
        .wr_data (alu_res),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    rfalu_alu #(.WIDTH(WIDTH)) u_alu (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op_e),
        .opnd_a (rd_data[P_A]),
        .opnd_b (opnd_b),
        .result (alu_res)
    );

    assign dbg_data = rd_data[P_DBG];

    AST_DEST_FROM_OLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_e == OP_MOV && dst != src_a) |=> (dbg_sel != $past(dst) || dbg_data == $past(rd_data[P_A]))); // R9

endmodule

// File: tb/rfalu_top_bench.sv
`timescale 1ns/1ps
module rfalu_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = '0, dst = '0, src_a = '0, src_b = '0, dbg_sel = '0;
    logic [15:0] imm = '0;
    logic        use_imm = 1'b0, wr_en = 1'b0;
    logic [15:0] dbg_data;

    logic [15:0] model [8];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rfalu_top u_rfalu_top (
        .clk(clk), .rst_n(rst_n), .op(op), .dst(dst), .src_a(src_a),
        .src_b(src_b), .imm(imm), .use_imm(use_imm), .wr_en(wr_en),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data)
    );

    function automatic logic [15:0] ref_alu(input logic [2:0] f, input logic [15:0] a, input logic [15:0] b);
        case (f)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return a;
            3'd6: return a << 1;
            default: return a >> 1;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] f);
        case (f)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2, 3'd3, 3'd4: return "R4";
            3'd5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reads a register through the debug port between edges.
    task automatic peek(input logic [2:0] r, output logic [15:0] v);
        dbg_sel = r;
        #0.5;
        v = dbg_data;
    endtask

    // Issues one instruction at the falling edge, then checks the destination.
    task automatic exec(input string tag, input logic [2:0] f, input logic [2:0] d,
                        input logic [2:0] a, input logic [2:0] b, input logic [15:0] k,
                        input logic ui, input logic we);
        logic [15:0] exp, got;
        @(negedge clk);
        op = f; dst = d; src_a = a; src_b = b; imm = k; use_imm = ui; wr_en = we;
        dbg_sel = d;
        exp = ref_alu(f, model[a], ui ? k : model[b]);
        @(posedge clk);
        #1;
        if (we) model[d] = exp;
        wr_en = 1'b0;
        peek(d, got);
        check(tag, got, model[d]);
    endtask

    task automatic load(input logic [2:0] r, input logic [15:0] v);
        exec("R4", 3'd4, r, r, r, 16'h0, 1'b0, 1'b1);
        exec("R7", 3'd0, r, r, 3'd0, v, 1'b1, 1'b1);
    endtask

    task automatic scan_all(input string tag);
        logic [15:0] v;
        for (int i = 0; i < 8; i++) begin
            peek(3'(i), v);
            check(tag, v, model[i]);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        scan_all("R1");                    // R1 reset clears all
        load(3'd0, 16'h1234);
        load(3'd3, 16'h0F0F);
        exec("R2", 3'd0, 3'd4, 3'd0, 3'd3, 16'h0, 1'b0, 1'b1);  // R2 example add
        load(3'd1, 16'hFFFF);
        load(3'd2, 16'h0001);
        exec("R2", 3'd0, 3'd5, 3'd1, 3'd2, 16'h0, 1'b0, 1'b1);  // R2 wrap to 0
        exec("R3", 3'd1, 3'd6, 3'd2, 3'd1, 16'h0, 1'b0, 1'b1);  // R3 1 - FFFF = 2
        exec("R6", 3'd6, 3'd7, 3'd1, 3'd0, 16'h0, 1'b0, 1'b1);  // R6 shl FFFF
        exec("R6", 3'd7, 3'd7, 3'd1, 3'd0, 16'h0, 1'b0, 1'b1);  // R6 shr FFFF
        exec("R5", 3'd5, 3'd6, 3'd0, 3'd1, 16'hAAAA, 1'b1, 1'b1);
        exec("R9", 3'd0, 3'd3, 3'd3, 3'd3, 16'h0, 1'b0, 1'b1);  // R9 old value doubled
        exec("R9", 3'd1, 3'd0, 3'd0, 3'd2, 16'h0, 1'b0, 1'b1);  // R9
        // R7: two runs differing only in src_b must give identical results
        load(3'd4, 16'h5000);
        exec("R7", 3'd0, 3'd5, 3'd4, 3'd1, 16'h0123, 1'b1, 1'b1);
        exec("R7", 3'd0, 3'd6, 3'd4, 3'd3, 16'h0123, 1'b1, 1'b1);
        check("R7", model[5], 16'h5123);
        // R8: write disabled leaves every register untouched
        exec("R8", 3'd1, 3'd2, 3'd1, 3'd4, 16'hDEAD, 1'b0, 1'b0);
        scan_all("R8");
        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [2:0] f;
            logic we;
            f = 3'($urandom);
            we = ($urandom % 8) != 0;
            exec(we ? tag_of(f) : "R8", f, 3'($urandom), 3'($urandom), 3'($urandom),
                 16'($urandom), 1'($urandom), we);
            if (n % 50 == 0) scan_all("R10");
        end
        // R1: reset in mid-run clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) model[i] = '0;
        scan_all("R1");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule